// File: doc/BRIEF.md
# Trap exception stack frame sequencer

This block builds the supervisor-stack frame that an instruction-generated trap leaves behind. The core hands it a request with a trap kind, the 4-bit immediate field of the trap instruction, the current status register, the address of the next instruction and the address of the trapping instruction, together with the current supervisor stack pointer. The block forms the vector number, then pushes the frame one 16-bit word at a time through a write port with a request/acknowledge handshake. When the last word is accepted, it reports completion and the new stack pointer.

A software trap instruction produces a short frame of four words: status register, return address, and a word that packs the frame format with the vector offset. Every other instruction trap (divide by zero, bounds check, conditional trap) produces a six-word frame. In that frame the address of the faulting instruction follows the packed word. Each frame word goes to the next lower even address, so the status register ends up at the final stack pointer. The handler can then read the frame upward from there.

Top module: `trap_frame_seq`

## Requirements
- R1: After synchronous reset, wr_en, done and busy are all low.
- R2: For kind 0 (software trap), vector_o equals 32 plus the 4-bit immediate, giving 32 to 47.
- R3: For kind 1 the vector is 5, for kind 2 it is 6, and for kind 3 it is 7. The immediate is ignored for these kinds.
- R4: A kind 0 trap writes exactly 4 words, and sp_out equals sp_in minus 8.
- R5: A kind 1 to 3 trap writes exactly 6 words, and sp_out equals sp_in minus 12.
- R6: The first write goes to sp_in minus 2, and each later write goes 2 below the previous one.
- R7: Relative to sp_out, the frame holds the status register at +0, the high half of next_pc at +2, its low half at +4 and the packed word at +6. A long frame also holds the high half of fault_pc at +8 and its low half at +10.
- R8: The packed word carries the format in bits 15:12 (0 for a short frame, 2 for a long frame) and the vector number times 4 in bits 11:0.
- R9: While wr_en is high and wr_ack is low, wr_addr and wr_data hold their values.
- R10: done is a single-cycle pulse. It is high in the cycle after the edge that accepts the last word, and wr_en is low while it is high.
- R11: A req_valid pulse while busy is high is ignored. The frame, the write count and vector_o are unaffected, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Trap request, taken only when idle |
| req_kind | input | 2 | 0 software trap, 1 divide by zero, 2 bounds check, 3 conditional trap |
| req_imm | input | 4 | Immediate field of the trap instruction |
| req_sr | input | 16 | Status register to save |
| req_next_pc | input | 32 | Address of the following instruction |
| req_fault_pc | input | 32 | Address of the trapping instruction |
| sp_in | input | 32 | Supervisor stack pointer before the push |
| wr_en | output | 1 | Stack write request |
| wr_addr | output | 32 | Byte address of the word being written |
| wr_data | output | 16 | Frame word being written |
| wr_ack | input | 1 | Write accepted at this edge |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle completion pulse |
| vector_o | output | 8 | Vector number of the last accepted trap |
| sp_out | output | 32 | Stack pointer after the push |

## Verification
Directed cases cover each kind: software traps with immediates 0 and 15, and each of the three fixed-vector kinds. These separate the computed vector from the fixed ones, and the short frame layout from the long one. Random traps mix kinds, immediates, status values, addresses and stack pointers with random acknowledge delays. This shows that every frame word lands at its own address with the right half of each address, and that the held write stays stable across a stall. A request injected while a frame is in progress shows that no second trap starts and that the first frame is left intact.

// File: rtl/trap_frame_pkg.sv
package trap_frame_pkg;
  localparam int WORD_W = 16;
  localparam int VEC_W  = 8;
  localparam int IMM_W  = 4;
  localparam int SLOT_W = 3;

  typedef enum logic [1:0] {
    TK_SWTRAP = 2'd0,
    TK_DIVZ   = 2'd1,
    TK_BOUNDS = 2'd2,
    TK_COND   = 2'd3
  } trap_kind_e;

  localparam logic [VEC_W-1:0] VEC_SW_BASE = 8'd32;
  localparam logic [VEC_W-1:0] VEC_DIVZ    = 8'd5;
  localparam logic [VEC_W-1:0] VEC_BOUNDS  = 8'd6;
  localparam logic [VEC_W-1:0] VEC_COND    = 8'd7;

  localparam logic [3:0] FMT_SHORT = 4'h0;
  localparam logic [3:0] FMT_LONG  = 4'h2;

  localparam int SHORT_WORDS = 4;
  localparam int LONG_WORDS  = 6;

  // slot numbering in push order over the long frame; short frames start at SLOT_FMT
  typedef enum logic [SLOT_W-1:0] {
    SLOT_FLT_LO = 3'd0,
    SLOT_FLT_HI = 3'd1,
    SLOT_FMT    = 3'd2,
    SLOT_PC_LO  = 3'd3,
    SLOT_PC_HI  = 3'd4,
    SLOT_SR     = 3'd5
  } frame_slot_e;
endpackage

// File: rtl/trap_vec_gen.sv
module trap_vec_gen
  import trap_frame_pkg::*;
(
  input  logic [1:0]       kind,
  input  logic [IMM_W-1:0] imm,
  output logic [VEC_W-1:0] vec,
  output logic             long_frame
);
  always_comb begin
    unique case (trap_kind_e'(kind))
      TK_SWTRAP: vec = VEC_SW_BASE + {{(VEC_W-IMM_W){1'b0}}, imm};
      TK_DIVZ:   vec = VEC_DIVZ;
      TK_BOUNDS: vec = VEC_BOUNDS;
      default:   vec = VEC_COND;
    endcase
    long_frame = (trap_kind_e'(kind) != TK_SWTRAP);
  end
endmodule

// File: rtl/frame_word_sel.sv
module frame_word_sel
  import trap_frame_pkg::*;
(
  input  logic [SLOT_W-1:0]   slot,
  input  logic [WORD_W-1:0]   sr,
  input  logic [2*WORD_W-1:0] next_pc,
  input  logic [2*WORD_W-1:0] fault_pc,
  input  logic [WORD_W-1:0]   fmt_word,
  output logic [WORD_W-1:0]   word
);
  always_comb begin
    unique case (frame_slot_e'(slot))
      SLOT_FLT_LO: word = fault_pc[WORD_W-1:0];
      SLOT_FLT_HI: word = fault_pc[2*WORD_W-1:WORD_W];
      SLOT_FMT:    word = fmt_word;
      SLOT_PC_LO:  word = next_pc[WORD_W-1:0];
      SLOT_PC_HI:  word = next_pc[2*WORD_W-1:WORD_W];
      default:     word = sr;
    endcase
  end
endmodule

// File: rtl/stack_addr_unit.sv
module stack_addr_unit #(
  parameter int AW = 32,
  parameter int STEP = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] sp_base,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] DEC = AW'(STEP);

  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (load) addr <= sp_base - DEC;
    else if (step) addr <= addr - DEC;
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (addr == $past(addr) - DEC)); // R6
endmodule

// File: rtl/trap_frame_seq.sv
module trap_frame_seq
  import trap_frame_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [IMM_W-1:0]  req_imm,
  input  logic [WORD_W-1:0] req_sr,
  input  logic [AW-1:0]     req_next_pc,
  input  logic [AW-1:0]     req_fault_pc,
  input  logic [AW-1:0]     sp_in,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [WORD_W-1:0] wr_data,
  input  logic              wr_ack,
  output logic              busy,
  output logic              done,
  output logic [VEC_W-1:0]  vector_o,
  output logic [AW-1:0]     sp_out
);
  localparam int PCW = 2 * WORD_W;
  localparam logic [AW-1:0] SHORT_BYTES = AW'(2 * SHORT_WORDS);
  localparam logic [AW-1:0] LONG_BYTES  = AW'(2 * LONG_WORDS);
  localparam logic [SLOT_W-1:0] SHORT_BASE = SLOT_W'(LONG_WORDS - SHORT_WORDS);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_PUSH, S_DONE} state_e;
  state_e state;

  logic [VEC_W-1:0]  vec_c, vec_q;
  logic              long_c, long_q;
  logic [WORD_W-1:0] sr_q;
  logic [PCW-1:0]    npc_q, fpc_q;
  logic [AW-1:0]     sp_q;
  logic [SLOT_W-1:0] idx;
  logic [SLOT_W-1:0] sel_slot;
  logic [SLOT_W-1:0] last_idx;
  logic [WORD_W-1:0] fmt_word, word_c;
  logic              is_last, accept;

  trap_vec_gen u_vec (
    .kind(req_kind), .imm(req_imm), .vec(vec_c), .long_frame(long_c)
  );

  assign fmt_word = {(long_q ? FMT_LONG : FMT_SHORT), 2'b00, vec_q, 2'b00};
  assign sel_slot = (long_q ? '0 : SHORT_BASE) + ((state == S_LOAD) ? '0 : idx + 1'b1);

  frame_word_sel u_word (
    .slot(sel_slot), .sr(sr_q), .next_pc(npc_q), .fault_pc(fpc_q),
    .fmt_word(fmt_word), .word(word_c)
  );

  assign accept   = (state == S_PUSH) && wr_ack;
  assign last_idx = long_q ? SLOT_W'(LONG_WORDS - 1) : SLOT_W'(SHORT_WORDS - 1);
  assign is_last  = (idx == last_idx);

  stack_addr_unit #(.AW(AW), .STEP(2)) u_addr (
    .clk(clk), .rst(rst),
    .load(state == S_LOAD),
    .step(accept && !is_last),
    .sp_base(sp_q),
    .addr(wr_addr)
  );

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      wr_en    <= 1'b0;
      wr_data  <= '0;
      done     <= 1'b0;
      vec_q    <= '0;
      long_q   <= 1'b0;
      sr_q     <= '0;
      npc_q    <= '0;
      fpc_q    <= '0;
      sp_q     <= '0;
      idx      <= '0;
      sp_out   <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (req_valid) begin
            vec_q  <= vec_c;
            long_q <= long_c;
            sr_q   <= req_sr;
            npc_q  <= PCW'(req_next_pc);
            fpc_q  <= PCW'(req_fault_pc);
            sp_q   <= sp_in;
            idx    <= '0;
            state  <= S_LOAD;
          end
        end
        S_LOAD: begin
          wr_en   <= 1'b1;
          wr_data <= word_c;
          state   <= S_PUSH;
        end
        S_PUSH: begin
          if (wr_ack) begin
            if (is_last) begin
              wr_en  <= 1'b0;
              done   <= 1'b1;
              sp_out <= sp_q - (long_q ? LONG_BYTES : SHORT_BYTES);
              state  <= S_DONE;
            end else begin
              idx     <= idx + 1'b1;
              wr_data <= word_c;
            end
          end
        end
        default: begin
          done  <= 1'b0;
          state <= S_IDLE;
        end
      endcase
    end
  end

  assign vector_o = vec_q;

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_ack) |=> (wr_en && $stable(wr_addr) && $stable(wr_data))); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_DONE_NO_WR: assert property (@(posedge clk) disable iff (rst)
    done |-> !wr_en); // R10
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(vector_o)); // R11
  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> (!wr_en && !done && !busy)); // R1
endmodule

// File: tb/tb_trap_frame_seq.sv
module tb_trap_frame_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = '0;
  logic [3:0]  req_imm = '0;
  logic [15:0] req_sr = '0;
  logic [31:0] req_next_pc = '0, req_fault_pc = '0, sp_in = '0;
  logic        wr_en, wr_ack = 1'b0, busy, done;
  logic [31:0] wr_addr, sp_out;
  logic [15:0] wr_data;
  logic [7:0]  vector_o;

  int checks = 0, errors = 0, cyc = 0;
  int nrec = 0, last_ack_cyc = 0, wait_cnt = 0;
  bit holding = 0;
  logic [31:0] hold_addr, rec_addr [0:15];
  logic [15:0] hold_data, rec_data [0:15];

  trap_frame_seq dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_imm(req_imm), .req_sr(req_sr), .req_next_pc(req_next_pc),
    .req_fault_pc(req_fault_pc), .sp_in(sp_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack), .busy(busy),
    .done(done), .vector_o(vector_o), .sp_out(sp_out)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 60000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 60000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // write responder with random stall
  always @(negedge clk) begin
    if (rst) begin
      wr_ack <= 1'b0; holding = 0;
    end else if (wr_ack) begin
      wr_ack <= 1'b0;
    end else if (wr_en) begin
      if (holding) chk(wr_addr == hold_addr && wr_data == hold_data, "R9 hold",
                       {wr_addr[15:0], wr_data}, {hold_addr[15:0], hold_data});
      if (wait_cnt == 0) begin
        if (nrec < 16) begin rec_addr[nrec] = wr_addr; rec_data[nrec] = wr_data; end
        nrec++;
        last_ack_cyc = cyc;
        wr_ack <= 1'b1;
        holding = 0;
        wait_cnt = int'($urandom % 3);
      end else begin
        holding = 1; hold_addr = wr_addr; hold_data = wr_data;
        wait_cnt--;
      end
    end
  end

  function automatic logic [7:0] exp_vec(input logic [1:0] k, input logic [3:0] imm);
    case (k)
      2'd0: exp_vec = 8'd32 + {4'd0, imm};
      2'd1: exp_vec = 8'd5;
      2'd2: exp_vec = 8'd6;
      default: exp_vec = 8'd7;
    endcase
  endfunction

  // expected word at byte offset from final sp
  function automatic logic [15:0] exp_word(input int off, input logic [1:0] k, input logic [3:0] imm,
      input logic [15:0] sr, input logic [31:0] pc, input logic [31:0] fpc);
    logic [7:0] v;
    v = exp_vec(k, imm);
    case (off)
      0: exp_word = sr;
      2: exp_word = pc[31:16];
      4: exp_word = pc[15:0];
      6: exp_word = {(k == 2'd0) ? 4'h0 : 4'h2, 2'b00, v, 2'b00};
      8: exp_word = fpc[31:16];
      default: exp_word = fpc[15:0];
    endcase
  endfunction

  task automatic run_trap(input logic [1:0] k, input logic [3:0] imm, input logic [15:0] sr,
      input logic [31:0] pc, input logic [31:0] fpc, input logic [31:0] sp, input bit inject);
    int n, t, saved;
    logic [31:0] fin;
    n = (k == 2'd0) ? 4 : 6;
    @(negedge clk);
    req_kind = k; req_imm = imm; req_sr = sr; req_next_pc = pc; req_fault_pc = fpc; sp_in = sp;
    req_valid = 1'b1; nrec = 0;
    @(negedge clk);
    req_valid = 1'b0;
    if (inject) begin
      repeat (3) @(negedge clk);
      chk(busy == 1'b1, "R11 busy during frame", 32'(busy), 1);
      req_kind = ~k; req_imm = ~imm; req_sr = ~sr; req_next_pc = ~pc; req_fault_pc = ~fpc;
      sp_in = sp - 32'h100; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    t = 0;
    while (!done && t < 200) begin @(negedge clk); t++; end
    chk(done == 1'b1, "R10 done seen", 32'(done), 1);
    chk(cyc == last_ack_cyc + 1, "R10 done timing", 32'(cyc), 32'(last_ack_cyc + 1));
    chk(wr_en == 1'b0, "R10 no write with done", 32'(wr_en), 0);
    chk(nrec == n, (n == 4) ? "R4 word count" : "R5 word count", 32'(nrec), 32'(n));
    chk(vector_o == exp_vec(k, imm), (k == 2'd0) ? "R2 vector" : "R3 vector",
        32'(vector_o), 32'(exp_vec(k, imm)));
    fin = sp - 32'(2 * n);
    chk(sp_out == fin, (n == 4) ? "R4 sp_out" : "R5 sp_out", sp_out, fin);
    for (int i = 0; i < n && i < nrec; i++) begin
      int off;
      chk(rec_addr[i] == sp - 32'(2 * (i + 1)), "R6 address", rec_addr[i], sp - 32'(2 * (i + 1)));
      off = int'(rec_addr[i] - fin);
      chk(rec_data[i] == exp_word(off, k, imm, sr, pc, fpc), (off == 6) ? "R8 packed word" : "R7 frame word",
          {16'd0, rec_data[i]}, {16'd0, exp_word(off, k, imm, sr, pc, fpc)});
    end
    @(negedge clk);
    chk(done == 1'b0, "R10 single pulse", 32'(done), 0);
    if (inject) begin
      saved = nrec;
      repeat (10) @(negedge clk);
      chk(nrec == saved && busy == 1'b0, "R11 no second frame", 32'(nrec), 32'(saved));
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!wr_en && !done && !busy, "R1 reset state", {29'd0, wr_en, done, busy}, 0);
    run_trap(2'd0, 4'd0,  16'h2700, 32'h0000_1002, 32'h0000_1000, 32'h0000_8000, 0); // R2 low
    run_trap(2'd0, 4'd15, 16'h2004, 32'hABCD_1234, 32'hABCD_1232, 32'h0001_0000, 0); // R2 high
    run_trap(2'd1, 4'd9,  16'h2010, 32'h1234_5678, 32'h1234_5676, 32'h0000_4000, 0); // R3 divz
    run_trap(2'd2, 4'd3,  16'h2701, 32'hFFFF_FFFE, 32'h8000_0000, 32'h0000_0010, 0); // R3 bounds
    run_trap(2'd3, 4'd7,  16'hFFFF, 32'h0000_0000, 32'hDEAD_BEEE, 32'h0000_0000, 0); // R3 wrap
    run_trap(2'd2, 4'd1,  16'h2000, 32'h0000_2000, 32'h0000_1FFC, 32'h0000_9000, 1); // R11
    for (int i = 0; i < 30; i++) begin
      run_trap(2'($urandom % 4), 4'($urandom), 16'($urandom), $urandom, $urandom,
               {$urandom % 32'h10_0000, 1'b0}, (i % 7) == 3);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule